// File: doc/BRIEF.md
# Translation Table Base Register File

This block is the register front end of an interrupt translation unit. It holds two 64-bit table-base registers, one locating the device table and one locating the collection table. They sit in an eight-slot window next to a control register and a read-only capability register. Software reaches all of these through a plain request/response bus that takes either 32-bit or 64-bit accesses.

Software never gets a value stored exactly as written. Every accepted table-base write first merges the written half, or the whole word, with the old contents. It then rewrites the result before storage:
- the type and entry-size fields are forced;
- physical address bits that are not supported are dropped;
- the page size is pinned to 64 KB;
- attribute encodings that are not supported are replaced;
- indirection is removed from the collection table.

While the unit is enabled, the table bases are frozen. The control register reports the enable bit together with a quiescent flag, which comes from the command engine next to this block.

Address map, as byte offsets:
- control at 0x000;
- capability at 0x008;
- the table window at 0x100, with slot n at 0x100 + 8n.

Any other address reads as zero and ignores writes.

Top module: `tbr_regfile`

## Requirements
- R1: After reset, slot 0 reads 0x1907_0000_0000_0600 and slot 1 reads 0x1C07_0000_0000_0600. Both hold inner cacheability 3, outer 0, shareability 1, entry-size field 7, page size 2, and type 1 or 4 respectively.
- R2: Window slots 2 to 7 always read zero, and writes to them change nothing.
- R3: On every accepted write, bits [52:48] are stored as 7 in both slots. Bits [58:56] are stored as 1 in slot 0 and as 4 in slot 1. The written values of these bits are discarded.
- R4: Bit 62 of slot 1 is always stored as 0. Bit 62 of slot 0 keeps the written value.
- R5: Bits [15:12] of both slots are always stored as 0, and bits [9:8] are always stored as 2.
- R6: The attribute fields are rewritten as follows:
  - shareability [11:10]: values 2 and 3 become 1;
  - inner cacheability [61:59]: value 0 becomes 1;
  - outer cacheability [55:53]: values 2 to 7 become 0.
  All other values of these fields are kept.
- R7: While the control enable bit is 1, writes to window slots are ignored.
- R8: A 32-bit access uses address bit 2 to pick the high half (1) or the low half (0). A 32-bit write is merged into the old 64-bit value before the rewriting of R3–R6. A 32-bit read returns the half in rdata[31:0] with rdata[63:32] zero.
- R9: The capability register at 0x008 reads 0x0000_0000_0001_EF01:
  - bit 0 set;
  - bits [12:8] = 0x0F;
  - bits [17:13] = 0x0F;
  - every other bit 0.
  Writes to it are ignored.
- R10: A write to control stores only wdata bit 0 as the enable, which also drives unit_en. A read of control returns the enable in bit 0 and cmd_idle in bit 31, with every other bit 0.
- R11: Read data and bus_rvalid appear in the cycle after a read request. bus_rvalid is low in the cycle after any cycle without a read request. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data; a 32-bit write uses bits [31:0] |
| cmd_idle | input | 1 | Command queue empty, reported as quiescent |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Read data |
| unit_en | output | 1 | Control enable bit |

## Verification
A write takes effect at the clock edge that samples it. Read data is registered, so a read returns in the cycle after its request. Read data therefore reflects every write issued in earlier cycles.

The bench drives each access on a falling edge. It holds the access for one rising edge, then samples bus_rdata and bus_rvalid at the following falling edge. That sample lands exactly one cycle after the request.

The lock and control checks issue the enabling write one full cycle before the blocked write. Each one then reads back in a separate later access.

// File: rtl/tbr_regfile.sv
module tbr_regfile #(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] WIN_BASE = 9'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  input  logic              cmd_idle,
  output logic              bus_rvalid,
  output logic [63:0]       bus_rdata,
  output logic              unit_en
);
  localparam logic [63:0] RST_DEV  = 64'h1907_0000_0000_0600;
  localparam logic [63:0] RST_COLL = 64'h1C07_0000_0000_0600;
  localparam logic [63:0] CAP_VAL  = 64'h0000_0000_0001_EF01;

  logic [63:0] dev_q, coll_q;

  wire in_win   = bus_addr[ADDR_W-1:6] == WIN_BASE[ADDR_W-1:6];
  wire [2:0] slot = bus_addr[5:3];
  wire hit_ctrl = bus_addr[ADDR_W-1:3] == '0;
  wire hit_cap  = bus_addr[ADDR_W-1:3] == {{(ADDR_W-4){1'b0}}, 1'b1};
  wire wr_go    = bus_req && bus_wr;
  wire rd_go    = bus_req && !bus_wr;
  wire win_wr   = wr_go && in_win && !unit_en;
  wire dev_wr   = win_wr && slot == 3'd0;
  wire coll_wr  = win_wr && slot == 3'd1;

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] wd,
                                        input logic wide, input logic hi);
    if (wide)    return wd;
    else if (hi) return {wd[31:0], old[31:0]};
    else         return {old[63:32], wd[31:0]};
  endfunction

  function automatic logic [63:0] scrub(input logic [63:0] v, input logic is_coll);
    logic [63:0] r;
    r = v;
    r[52:48] = 5'd7;
    r[58:56] = is_coll ? 3'd4 : 3'd1;
    if (is_coll) r[62] = 1'b0;
    r[15:12] = 4'd0;
    r[9:8]   = 2'd2;
    if (r[11:10] >= 2'd2) r[11:10] = 2'd1;
    if (r[61:59] == 3'd0) r[61:59] = 3'd1;
    if (r[55:53] >= 3'd2) r[55:53] = 3'd0;
    return r;
  endfunction

  wire [63:0] cur_win = (slot == 3'd0) ? dev_q : coll_q;
  wire [63:0] new_win = scrub(merge(cur_win, bus_wdata, bus_wide, bus_addr[2]), slot == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q  <= RST_DEV;
      coll_q <= RST_COLL;
    end else begin
      if (dev_wr)  dev_q  <= new_win;
      if (coll_wr) coll_q <= new_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      unit_en <= 1'b0;
    else if (wr_go && hit_ctrl && (bus_wide || !bus_addr[2]))
      unit_en <= bus_wdata[0];
  end

  logic [63:0] rd_full;
  always_comb begin
    rd_full = '0;
    if (hit_ctrl)    rd_full = {32'd0, cmd_idle, 30'd0, unit_en};
    else if (hit_cap) rd_full = CAP_VAL;
    else if (in_win && slot == 3'd0) rd_full = dev_q;
    else if (in_win && slot == 3'd1) rd_full = coll_q;
  end

  wire [63:0] rd_sized = bus_wide ? rd_full :
                         bus_addr[2] ? {32'd0, rd_full[63:32]} : {32'd0, rd_full[31:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_go;
      if (rd_go) bus_rdata <= rd_sized;
    end
  end

  a_r7_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && in_win && unit_en) |=> ($stable(dev_q) && $stable(coll_q)));
  a_r3_forced_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && in_win && slot == 3'd0 && !unit_en) |=>
      (dev_q[52:48] == 5'd7 && dev_q[58:56] == 3'd1));
  a_r4_no_indirect: assert property (@(posedge clk) disable iff (!rst_n) !coll_q[62]);
  a_r5_addr_page: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_q[15:12] == 4'd0 && coll_q[15:12] == 4'd0 && dev_q[9:8] == 2'd2 && coll_q[9:8] == 2'd2));
  a_r10_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == '0) |=> (unit_en == $past(bus_wdata[0])));
  a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> bus_rvalid);
  a_r11_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_wr) |=> !bus_rvalid);
endmodule

// File: tb/tbr_regfile_tb.sv
`timescale 1ns/1ps
module tbr_regfile_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, wide = 1'b0, idle = 1'b1;
  logic [8:0] addr = '0;
  logic [63:0] wdata = '0;
  logic rvalid, en;
  logic [63:0] rdata;
  int nchk = 0, nbad = 0;

  always #4 clk = ~clk;

  tbr_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_wr(wr), .bus_wide(wide),
    .bus_addr(addr), .bus_wdata(wdata), .cmd_idle(idle),
    .bus_rvalid(rvalid), .bus_rdata(rdata), .unit_en(en)
  );

  typedef struct packed {
    logic [8:0]  a;
    logic        w64;
    logic [63:0] d;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{9'h100, 1'b1, 64'h0000_0000_0000_0000, 64'h0907_0000_0000_0200},
    '{9'h100, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF907_FFFF_FFFF_06FF},
    '{9'h108, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hBC07_FFFF_FFFF_06FF},
    '{9'h108, 1'b1, 64'h0000_1234_5678_F000, 64'h0C07_1234_5678_0200},
    '{9'h100, 1'b1, 64'h1020_0000_0000_0800, 64'h1127_0000_0000_0600},
    '{9'h100, 1'b1, 64'h28A0_0000_0000_0400, 64'h2907_0000_0000_0600},
    '{9'h100, 1'b0, 64'h0000_0000_ABCD_1234, 64'h2907_0000_ABCD_0234},
    '{9'h104, 1'b0, 64'h0000_0000_0000_00FF, 64'h0907_00FF_ABCD_0234},
    '{9'h118, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    '{9'h138, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic w64, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; wide = w64; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] a, input logic w64, output logic [63:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; wide = w64; addr = a;
    @(negedge clk);
    req = 1'b0;
    check("R11 rvalid after read", {63'd0, rvalid}, 64'd1);
    d = rdata;
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 unit_en after reset", {63'd0, en}, 64'd0);
    do_read(9'h100, 1'b1, r); check("R1 slot0 reset", r, 64'h1907_0000_0000_0600);
    do_read(9'h108, 1'b1, r); check("R1 slot1 reset", r, 64'h1C07_0000_0000_0600);
    do_read(9'h008, 1'b1, r); check("R9 capability", r, 64'h0000_0000_0001_EF01);
    do_read(9'h000, 1'b0, r); check("R10 ctrl read idle", r, 64'h0000_0000_8000_0000);
    do_read(9'h104, 1'b0, r); check("R8 32-bit high read", r, 64'h0000_0000_1907_0000);
    do_read(9'h100, 1'b0, r); check("R8 32-bit low read", r, 64'h0000_0000_0000_0600);
    @(negedge clk);
    check("R11 no rvalid when idle", {63'd0, rvalid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].a, VEC[i].w64, VEC[i].d);
      do_read({VEC[i].a[8:3], 3'b000}, 1'b1, r);
      check($sformatf("R2/R3/R4/R5/R6/R8 vector %0d", i), r, VEC[i].exp);
    end

    do_write(9'h008, 1'b1, 64'h0);
    do_read(9'h008, 1'b1, r); check("R9 capability write ignored", r, 64'h0000_0000_0001_EF01);
    do_read(9'h040, 1'b1, r); check("R11 unmapped reads zero", r, 64'h0);

    do_write(9'h000, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 unit_en set", {63'd0, en}, 64'd1);
    do_read(9'h000, 1'b1, r); check("R10 ctrl only enable stored", r, 64'h0000_0000_8000_0001);
    do_write(9'h100, 1'b1, 64'h0);
    do_write(9'h108, 1'b1, 64'h0);
    do_read(9'h100, 1'b1, r); check("R7 slot0 locked", r, 64'h0907_00FF_ABCD_0234);
    do_read(9'h108, 1'b1, r); check("R7 slot1 locked", r, 64'h0C07_1234_5678_0200);
    idle = 1'b0;
    do_read(9'h000, 1'b0, r); check("R10 quiescent low", r, 64'h0000_0000_0000_0001);
    do_write(9'h000, 1'b1, 64'h0000_0000_0000_0000);
    check("R10 unit_en cleared", {63'd0, en}, 64'd0);
    do_write(9'h108, 1'b1, 64'h4000_0000_0000_0000);
    do_read(9'h108, 1'b1, r); check("R4 slot1 write after unlock", r, 64'h0C07_0000_0000_0200);
    do_write(9'h100, 1'b1, 64'h4000_0000_0000_0000);
    do_read(9'h100, 1'b1, r); check("R4 slot0 keeps bit62", r, 64'h4907_0000_0000_0200);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule